// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character into an asynchronous-style serial frame on a single output line. The frame shape is chosen per character from three run-time inputs: the data length (5 to 9 bits), the parity mode (none, even or odd) and the stop count (one or two). That gives all 30 legal combinations. A character is offered on a valid/ready handshake. The line advances one bit on each pulse of an external shift strobe, which comes from a baud divider or a synchronous clock unit that sits outside this block.

Each frame has the same layout. First comes a low start bit. Next come the data bits, lowest first. The optional parity bit follows the data, and the high stop bits come last. Between frames the line rests high. A one-entry holding slot lets the next character be accepted during the last stop bit. That character then begins on the strobe that ends the current frame, with no idle bit in between. Two status outputs show whether work is outstanding and mark the end of every frame.

Top module: `frame_tx`

## Requirements
- R1: After reset and whenever nothing is pending or in flight, tx_o is high, ready_o is high, busy_o is low and done_o is low; strobes while idle leave tx_o high.
- R2: An accepted character starts with one low start bit, which appears on the first strobe after the accepting clock edge and lasts one strobe period.
- R3: Data bits follow the start bit, least significant bit first. len_i selects the count as 5 + len_i for codes 0 to 4; codes 5, 6 and 7 select 9 bits.
- R4: par_i code 1 is even parity and code 2 is odd parity. The bit follows the last data bit and makes the XOR of the sent data bits and itself 0 (even) or 1 (odd). Codes 0 and 3 send no parity bit.
- R5: After the data bits (or after the parity bit when present), the frame ends with one high stop bit when stop2_i is 0, or two when it is 1.
- R6: Data and format inputs are captured at the accepting edge; changing them afterwards does not alter that frame.
- R7: ready_o is low while a frame is in flight, except during its last stop bit when no character is waiting; a character is taken on a clock edge with valid_i and ready_o both high.
- R8: A character accepted during the last stop bit starts its start bit on the strobe that ends that stop bit, with no idle bit between frames.
- R9: done_o is a one-cycle pulse in the cycle after the strobe that ends the final stop bit of each frame.
- R10: busy_o rises in the cycle after acceptance and stays high until a frame ends with no character waiting.
- R11: tx_o changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle bit-shift strobe |
| data_i | input | 9 | Character, bit 0 sent first |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character can be taken this cycle |
| len_i | input | 3 | Data length code (5 + code, 9 for codes of 4 and above) |
| par_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| stop2_i | input | 1 | 1 selects two stop bits |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | A character is waiting or in flight |
| done_o | output | 1 | Pulse marking the end of a frame |

## Verification
Every result is due one clock after a strobe edge: the new line bit, the done pulse and the drop of busy at the frame end. Acceptance is visible in busy_o and ready_o one clock after the handshake edge, while the line stays high until the next strobe. The bench drives strobes on falling edges, waits for the rising edge at which a strobe is seen, and samples at the following falling edge. It then samples once more a cycle later to confirm that the line holds its value between strobes. Back-to-back timing is checked by offering the next character only after the last stop bit has been observed, and by expecting its start bit and the done pulse together one strobe later.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int DMAX    = 9;
  localparam int DMIN    = 5;
  localparam int LEN_W   = 3;
  localparam int FRAME_W = DMAX + 4;  // start + data + parity + 2 stop
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;  // bit 0 goes out first
    logic [CNT_W-1:0]   n;
  } frame_t;
endpackage

// File: rtl/frame_tx_fmt.sv
module frame_tx_fmt
  import frame_tx_pkg::*;
(
  input  logic [DMAX-1:0]  data_i,
  input  logic [LEN_W-1:0] len_i,
  input  par_e             par_i,
  input  logic             stop2_i,
  output frame_t           frame_o
);
  int   nd;
  logic has_par;
  logic par_bit;

  always_comb begin
    nd      = (len_i > LEN_W'(DMAX - DMIN)) ? DMAX : DMIN + int'(len_i);
    has_par = (par_i == PAR_EVEN) || (par_i == PAR_ODD);
    par_bit = (par_i == PAR_ODD);
    frame_o.bits    = '1;
    frame_o.bits[0] = 1'b0;
    for (int i = 0; i < DMAX; i++) begin
      if (i < nd) begin
        frame_o.bits[i+1] = data_i[i];
        par_bit = par_bit ^ data_i[i];
      end
    end
    for (int i = 1; i < FRAME_W; i++) begin
      if (has_par && i == nd + 1) frame_o.bits[i] = par_bit;
    end
    frame_o.n = CNT_W'(nd + 2 + (has_par ? 1 : 0) + (stop2_i ? 1 : 0));
  end
endmodule

// File: rtl/frame_tx_hold.sv
module frame_tx_hold
  import frame_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  frame_t frame_i,
  input  logic   take_i,
  output logic   full_o,
  output frame_t frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o  <= 1'b0;
      frame_o <= '0;
    end else if (load_i) begin
      full_o  <= 1'b1;
      frame_o <= frame_i;
    end else if (take_i) begin
      full_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_tx_serial.sv
module frame_tx_serial
  import frame_tx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   start_i,
  input  frame_t frame_i,
  output logic   tx_o,
  output logic   active_o,
  output logic   last_o,
  output logic   done_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  assign last_o = active_o && (cnt_q == CNT_W'(1));
  assign tx_o   = active_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '1;
      cnt_q    <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= tick_i && last_o;
      if (start_i) begin
        sh_q     <= frame_i.bits;
        cnt_q    <= frame_i.n;
        active_o <= 1'b1;
      end else if (tick_i && active_o) begin
        if (last_o) begin
          active_o <= 1'b0;
        end else begin
          sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DMAX-1:0]  data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       par_i,
  input  logic             stop2_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             done_o
);
  frame_t cur_frame, pend_frame, start_frame;
  logic   pend_full, active, last;
  logic   accept, direct, load_pend, start, take;

  frame_tx_fmt u_fmt (
    .data_i  (data_i),
    .len_i   (len_i),
    .par_i   (par_e'(par_i)),
    .stop2_i (stop2_i),
    .frame_o (cur_frame)
  );

  assign ready_o   = !pend_full && (!active || last);
  assign accept    = valid_i && ready_o;
  // accepted on the very strobe that closes the frame: skip the slot
  assign direct    = accept && last && tick_i;
  assign load_pend = accept && !direct;
  assign start     = tick_i && (!active || last) && (pend_full || direct);
  assign take      = start && pend_full;
  assign start_frame = pend_full ? pend_frame : cur_frame;
  assign busy_o    = active || pend_full;

  frame_tx_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_pend),
    .frame_i (cur_frame),
    .take_i  (take),
    .full_o  (pend_full),
    .frame_o (pend_frame)
  );

  frame_tx_serial u_serial (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (start),
    .frame_i  (start_frame),
    .tx_o     (tx_o),
    .active_o (active),
    .last_o   (last),
    .done_o   (done_o)
  );
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic valid_i,
  input logic ready_o,
  input logic tx_o,
  input logic busy_o,
  input logic done_o
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  assert_idle_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ready_o);

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> busy_o);

  assert_done_after_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tick_i));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(tx_o));
endmodule

bind frame_tx frame_tx_chk u_chk (.*);

// File: tb/frame_tx_bench.sv
module frame_tx_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [8:0] data = '0;
  logic       valid = 1'b0;
  logic [2:0] len = '0;
  logic [1:0] par = '0;
  logic       stop2 = 1'b0;
  logic       tx, ready, busy, done;
  int         div = 0;
  int         errors = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div  <= (div == DIV - 1) ? 0 : div + 1;
    tick <= (div == DIV - 1);
  end

  frame_tx u_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .data_i(data),
    .valid_i(valid), .ready_o(ready), .len_i(len), .par_i(par),
    .stop2_i(stop2), .tx_o(tx), .busy_o(busy), .done_o(done)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits_of(int l, int p, bit s);
    int nd = (l > 4) ? 9 : l + 5;
    return 1 + nd + ((p == 1 || p == 2) ? 1 : 0) + (s ? 2 : 1);
  endfunction

  function automatic int exp_bit(logic [8:0] d, int l, int p, bit s, int idx);
    int nd = (l > 4) ? 9 : l + 5;
    bit pb = (p == 2);
    for (int i = 0; i < nd; i++) pb ^= d[i];
    if (idx == 0) return 0;
    if (idx <= nd) return int'(d[idx-1]);
    if ((p == 1 || p == 2) && idx == nd + 1) return int'(pb);
    return 1;
  endfunction

  // returns at the falling edge after the rising edge that saw a strobe
  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(logic [8:0] d, int l, int p, bit s, bit scramble);
    data = d; len = 3'(l); par = 2'(p); stop2 = s; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (scramble) begin
      data = ~d; len = 3'(l ^ 3); par = 2'(p ^ 3); stop2 = ~s;
    end
  endtask

  // checks every bit; returns at a falling edge inside the last stop bit
  task automatic verify_bits(logic [8:0] d, int l, int p, bit s, bit b2b, string req);
    int n = nbits_of(l, p, s);
    for (int idx = 0; idx < n; idx++) begin
      wait_tick();
      check($sformatf("%s bit%0d", req, idx), int'(tx), exp_bit(d, l, p, s, idx));
      if (idx == 0) begin
        check("R2 start low", int'(tx), 0);
        check("R7 ready low in frame", int'(ready), 0);
        check("R10 busy in frame", int'(busy), 1);
        if (b2b) check("R8 done with next start", int'(done), 1);
      end
      if (idx == n - 1) check("R7 ready in last stop", int'(ready), 1);
      @(negedge clk);
      check("R11 tx held between strobes", int'(tx), exp_bit(d, l, p, s, idx));
    end
  endtask

  task automatic finish_idle(string req);
    wait_tick();
    check({req, " R9 done pulse"}, int'(done), 1);
    check("R1 line idle high", int'(tx), 1);
    check("R10 busy cleared", int'(busy), 0);
    check("R7 ready idle", int'(ready), 1);
    @(negedge clk);
    check("R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset tx", int'(tx), 1);
    check("R1 reset ready", int'(ready), 1);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset done", int'(done), 0);
    wait_tick();
    wait_tick();
    check("R1 idle strobes keep high", int'(tx), 1);
  endtask

  task automatic t_basic();
    send(9'h0A5, 3, 0, 1'b0, 1'b0);
    check("R10 busy after accept", int'(busy), 1);
    check("R2 no start before strobe", int'(tx), 1);
    check("R7 ready low while waiting", int'(ready), 0);
    verify_bits(9'h0A5, 3, 0, 1'b0, 1'b0, "R3 8N1");
    finish_idle("R5");
  endtask

  task automatic t_lengths();
    for (int l = 0; l < 8; l++) begin
      if (l == 5 || l == 7) continue;
      send(9'h1B6 ^ 9'(l), l, l % 3, l[0], 1'b0);
      verify_bits(9'h1B6 ^ 9'(l), l, l % 3, l[0], 1'b0, "R3 length");
      finish_idle("R5");
    end
  endtask

  task automatic t_parity();
    send(9'h00B, 3, 1, 1'b0, 1'b0);
    verify_bits(9'h00B, 3, 1, 1'b0, 1'b0, "R4 even");
    finish_idle("R4");
    send(9'h00B, 3, 2, 1'b1, 1'b0);
    verify_bits(9'h00B, 3, 2, 1'b1, 1'b0, "R4 odd");
    finish_idle("R4");
    send(9'h003, 3, 2, 1'b0, 1'b0);
    verify_bits(9'h003, 3, 2, 1'b0, 1'b0, "R4 odd even-weight");
    finish_idle("R4");
    send(9'h003, 3, 3, 1'b0, 1'b0);
    verify_bits(9'h003, 3, 3, 1'b0, 1'b0, "R4 code3 none");
    finish_idle("R4");
  endtask

  task automatic t_capture();
    send(9'h12C, 4, 1, 1'b1, 1'b1);
    verify_bits(9'h12C, 4, 1, 1'b1, 1'b0, "R6 captured");
    finish_idle("R6");
  endtask

  task automatic t_b2b();
    send(9'h055, 0, 0, 1'b0, 1'b0);
    verify_bits(9'h055, 0, 0, 1'b0, 1'b0, "R8 first");
    send(9'h1C3, 4, 2, 1'b1, 1'b0);
    check("R7 ready low with one waiting", int'(ready), 0);
    verify_bits(9'h1C3, 4, 2, 1'b1, 1'b1, "R8 second");
    finish_idle("R8");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_capture();
    t_b2b();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule